// File: doc/BRIEF.md
# APB Multi-Bus Transfer Monitor

The block listens to as many as four APB3 buses at once and reduces every transfer that completes on them to a single record. A record carries the cycle stamp of completion, the index of the bus it came from, the direction, the address, the data word and the response. The monitor has no output toward any bus. It only samples the select, enable, write, address, data, ready and error signals, so it cannot drive or stall the traffic it watches.

Each bus has its own small queue. A merge stage drains the queues into one record stream with a valid/ready handshake. When several queues hold records, the lowest bus index is served first. Each bus has parameters that declare its ready and error inputs absent, in which case they read as fixed defaults. Another per-bus parameter sets the address width, and address bits above that width read as zero. When a queue is full, further records from that bus are lost, and a sticky per-bus flag marks the loss.

Top module: `apb_txn_monitor`

## Requirements
- R1: A transfer completes in a cycle where select, enable and effective ready are all high on its bus at the rising edge. Exactly one record reaches the output stream for each completion that is not dropped.
- R2: For a bus whose bit in HAS_READY is 0, the ready input is ignored and the effective ready is taken as 1.
- R3: `recErr` is 1 (ERR) when the error input was high at completion and 0 (OK) otherwise. For a bus whose bit in HAS_ERR is 0, the error input is ignored and the record always reports OK.
- R4: `recWrite` copies the write input at completion (1 means write, 0 means read). `recData` holds the write data for writes and the read data for reads, both sampled in the completing cycle.
- R5: The address field keeps the low ADDR_BITS_VEC[6*i+5:6*i] bits of bus i's address, and every higher bit is zero. 32 or more keeps the whole word.
- R6: `recBus` holds the index i of the bus the record came from, where bus i uses bit i (or slice i) of every per-bus input vector.
- R7: `recTime` is an edge count. The first rising edge after reset release counts as 0, and each later rising edge adds 2, modulo 2^32. A record carries the value at its completing edge.
- R8: A record appears at the output from the cycle after its completion. Each bus queues up to FIFO_DEPTH (default 4) records in order. When no record is stalled, the output shows the oldest record of the lowest-indexed non-empty queue.
- R9: A completion that finds its bus queue full (FIFO_DEPTH entries before that edge) is dropped, and bit i of `overflow` is set. That bit stays set until reset.
- R10: While `recValid` is high and `recReady` is low, the offered record stays unchanged at the next edge. A record leaves the stream only on an edge where `recValid` and `recReady` are both high.
- R11: During reset, `recValid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the observed buses |
| rstN | input | 1 | Asynchronous active-low reset |
| pSel | input | NUM_BUS | Select input of each bus |
| pEnable | input | NUM_BUS | Enable (access phase) input of each bus |
| pWrite | input | NUM_BUS | Direction input of each bus |
| pReady | input | NUM_BUS | Ready input of each bus (ignored where absent) |
| pSlvErr | input | NUM_BUS | Error input of each bus (ignored where absent) |
| pAddr | input | NUM_BUS*ADDR_W | Address of each bus, bus i in slice i |
| pWdata | input | NUM_BUS*DATA_W | Write data of each bus |
| pRdata | input | NUM_BUS*DATA_W | Read data of each bus |
| recValid | output | 1 | A record is offered |
| recReady | input | 1 | Consumer accepts the offered record |
| recTime | output | 32 | Edge stamp of the completing transfer |
| recBus | output | 2 | Source bus index |
| recWrite | output | 1 | 1 write, 0 read |
| recAddr | output | 32 | Masked transfer address |
| recData | output | DATA_W | Transferred data word |
| recErr | output | 1 | 1 ERR, 0 OK |
| overflow | output | NUM_BUS | Sticky per-bus drop flags |

## Verification
Directed patterns come first. A lone write checks field capture and latency. A read beyond a narrowed address width checks the masking. Transfers on buses with absent ready or error inputs, driven with the opposite level on those inputs, show that the defaults take effect. A cycle where all four buses complete together checks the merge order. A stalled consumer facing back-to-back completions on one bus separates a correct drop-and-flag from a lost, duplicated or reordered record, and shows whether the offered record holds still. A long stretch of random bus activity with random consumer back-pressure follows. A behavioural queue model checks it on every clock, which catches mistakes in the timestamps, the priority and the hold after a stall.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;

  localparam int MAX_BUS = 4;
  localparam int MAX_W   = 32;

  typedef struct packed {
    logic [31:0]      stamp;
    logic [1:0]       busIdx;
    logic             isWrite;
    logic [MAX_W-1:0] addr;
    logic [MAX_W-1:0] data;
    logic             isErr;
  } txnRec_t;

  typedef struct packed {
    logic [MAX_BUS-1:0] push;
    logic [MAX_BUS-1:0] pop;
    logic [1:0]         selIdx;
  } ctrlStrobes_t;

  function automatic logic [MAX_W-1:0] lowMask(input int unsigned bits);
    if (bits >= MAX_W) return '1;
    return (32'd1 << bits) - 32'd1;
  endfunction

endpackage

// File: rtl/apb_mon_fifo.sv
module apb_mon_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    level;

  function automatic logic [PW-1:0] stepPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= stepPtr(wrPtr);
      if (pop)  rdPtr <= stepPtr(rdPtr);
      level <= level + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= wrData;
  end

  assign headData = slots[rdPtr];
  assign full     = (level == CW'(DEPTH));
  assign empty    = (level == '0);

endmodule

// File: rtl/apb_mon_datapath.sv
module apb_mon_datapath
  import apb_mon_pkg::*;
#(
  parameter int                    NUM_BUS       = 4,
  parameter int                    ADDR_W        = 32,
  parameter int                    DATA_W        = 32,
  parameter int                    FIFO_DEPTH    = 4,
  parameter logic [NUM_BUS*6-1:0]  ADDR_BITS_VEC = {NUM_BUS{6'd32}},
  parameter logic [NUM_BUS-1:0]    HAS_ERR       = '1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_BUS-1:0]        pWrite,
  input  logic [NUM_BUS-1:0]        pSlvErr,
  input  logic [NUM_BUS*ADDR_W-1:0] pAddr,
  input  logic [NUM_BUS*DATA_W-1:0] pWdata,
  input  logic [NUM_BUS*DATA_W-1:0] pRdata,
  input  ctrlStrobes_t              stb,
  output logic [NUM_BUS-1:0]        fifoFull,
  output logic [NUM_BUS-1:0]        fifoEmpty,
  output txnRec_t                   outRec,
  output logic [31:0]               timeNow
);
  localparam int REC_W = $bits(txnRec_t);

  logic [31:0] timeCnt;
  txnRec_t     newRec [NUM_BUS];
  txnRec_t     heads  [NUM_BUS];

  // Edge stamp: two edges per clock cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeCnt <= '0;
    else       timeCnt <= timeCnt + 32'd2;
  end
  assign timeNow = timeCnt;

  for (genvar i = 0; i < NUM_BUS; i++) begin : g_bus
    localparam int unsigned AB_RAW = ADDR_BITS_VEC[i*6 +: 6];
    localparam int unsigned AB     = (AB_RAW > ADDR_W) ? ADDR_W : AB_RAW;
    localparam logic [MAX_W-1:0] AMASK = lowMask(AB);

    logic [MAX_W-1:0] addrWide, wdWide, rdWide;
    logic [REC_W-1:0] headBits;

    assign addrWide = MAX_W'(pAddr[i*ADDR_W +: ADDR_W]);
    assign wdWide   = MAX_W'(pWdata[i*DATA_W +: DATA_W]);
    assign rdWide   = MAX_W'(pRdata[i*DATA_W +: DATA_W]);

    always_comb begin
      newRec[i].stamp   = timeCnt;
      newRec[i].busIdx  = 2'(i);
      newRec[i].isWrite = pWrite[i];
      newRec[i].addr    = addrWide & AMASK;
      newRec[i].data    = pWrite[i] ? wdWide : rdWide;
      newRec[i].isErr   = HAS_ERR[i] ? pSlvErr[i] : 1'b0;
    end

    apb_mon_fifo #(
      .WIDTH(REC_W),
      .DEPTH(FIFO_DEPTH)
    ) u_fifo (
      .clk     (clk),
      .rstN    (rstN),
      .push    (stb.push[i]),
      .pop     (stb.pop[i]),
      .wrData  (newRec[i]),
      .headData(headBits),
      .full    (fifoFull[i]),
      .empty   (fifoEmpty[i])
    );

    assign heads[i] = headBits;
  end

  always_comb begin
    outRec = '0;
    for (int i = 0; i < NUM_BUS; i++) begin
      if (stb.selIdx == 2'(i)) outRec = heads[i];
    end
  end

endmodule

// File: rtl/apb_mon_ctrl.sv
module apb_mon_ctrl
  import apb_mon_pkg::*;
#(
  parameter int                 NUM_BUS   = 4,
  parameter logic [NUM_BUS-1:0] HAS_READY = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUS-1:0] pSel,
  input  logic [NUM_BUS-1:0] pEnable,
  input  logic [NUM_BUS-1:0] pReady,
  input  logic               recReady,
  input  logic [NUM_BUS-1:0] fifoFull,
  input  logic [NUM_BUS-1:0] fifoEmpty,
  output ctrlStrobes_t       stb,
  output logic               recValid,
  output logic [NUM_BUS-1:0] overflow
);
  logic [NUM_BUS-1:0] readyEff, complete, pushVec, popVec;
  logic [1:0]         lowIdx, grantIdx, heldIdx;
  logic               held;

  assign readyEff = pReady | ~HAS_READY;
  assign complete = pSel & pEnable & readyEff;
  assign pushVec  = complete & ~fifoFull;
  assign recValid = |(~fifoEmpty);

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_BUS - 1; i >= 0; i--) begin
      if (!fifoEmpty[i]) lowIdx = 2'(i);
    end
  end

  assign grantIdx = held ? heldIdx : lowIdx;

  always_comb begin
    for (int i = 0; i < NUM_BUS; i++) begin
      popVec[i] = recValid && recReady && (grantIdx == 2'(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow <= '0;
      held     <= 1'b0;
      heldIdx  <= '0;
    end else begin
      overflow <= overflow | (complete & fifoFull);
      held     <= recValid && !recReady;
      heldIdx  <= grantIdx;
    end
  end

  always_comb begin
    stb        = '0;
    stb.push   = MAX_BUS'(pushVec);
    stb.pop    = MAX_BUS'(popVec);
    stb.selIdx = grantIdx;
  end

endmodule

// File: rtl/apb_txn_monitor.sv
module apb_txn_monitor
  import apb_mon_pkg::*;
#(
  parameter int                   NUM_BUS       = 4,
  parameter int                   ADDR_W        = 32,
  parameter int                   DATA_W        = 32,
  parameter int                   FIFO_DEPTH    = 4,
  parameter logic [NUM_BUS*6-1:0] ADDR_BITS_VEC = {NUM_BUS{6'd32}},
  parameter logic [NUM_BUS-1:0]   HAS_READY     = '1,
  parameter logic [NUM_BUS-1:0]   HAS_ERR       = '1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_BUS-1:0]        pSel,
  input  logic [NUM_BUS-1:0]        pEnable,
  input  logic [NUM_BUS-1:0]        pWrite,
  input  logic [NUM_BUS-1:0]        pReady,
  input  logic [NUM_BUS-1:0]        pSlvErr,
  input  logic [NUM_BUS*ADDR_W-1:0] pAddr,
  input  logic [NUM_BUS*DATA_W-1:0] pWdata,
  input  logic [NUM_BUS*DATA_W-1:0] pRdata,
  output logic                      recValid,
  input  logic                      recReady,
  output logic [31:0]               recTime,
  output logic [1:0]                recBus,
  output logic                      recWrite,
  output logic [31:0]               recAddr,
  output logic [DATA_W-1:0]         recData,
  output logic                      recErr,
  output logic [NUM_BUS-1:0]        overflow
);
  ctrlStrobes_t       ctrlStb;
  logic [NUM_BUS-1:0] fifoFull, fifoEmpty;
  txnRec_t            outRec;
  logic [31:0]        timeNow;
  logic [MAX_BUS-1:0] popVec;

  apb_mon_ctrl #(
    .NUM_BUS  (NUM_BUS),
    .HAS_READY(HAS_READY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pSel     (pSel),
    .pEnable  (pEnable),
    .pReady   (pReady),
    .recReady (recReady),
    .fifoFull (fifoFull),
    .fifoEmpty(fifoEmpty),
    .stb      (ctrlStb),
    .recValid (recValid),
    .overflow (overflow)
  );

  apb_mon_datapath #(
    .NUM_BUS      (NUM_BUS),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .FIFO_DEPTH   (FIFO_DEPTH),
    .ADDR_BITS_VEC(ADDR_BITS_VEC),
    .HAS_ERR      (HAS_ERR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pWrite   (pWrite),
    .pSlvErr  (pSlvErr),
    .pAddr    (pAddr),
    .pWdata   (pWdata),
    .pRdata   (pRdata),
    .stb      (ctrlStb),
    .fifoFull (fifoFull),
    .fifoEmpty(fifoEmpty),
    .outRec   (outRec),
    .timeNow  (timeNow)
  );

  assign popVec   = ctrlStb.pop;
  assign recTime  = outRec.stamp;
  assign recBus   = outRec.busIdx;
  assign recWrite = outRec.isWrite;
  assign recAddr  = outRec.addr;
  assign recData  = outRec.data[DATA_W-1:0];
  assign recErr   = outRec.isErr;

endmodule

// File: rtl/apb_mon_checker.sv
module apb_mon_checker #(
  parameter int NUM_BUS = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               recValid,
  input logic               recReady,
  input logic [31:0]        recTime,
  input logic [1:0]         recBus,
  input logic               recWrite,
  input logic [31:0]        recAddr,
  input logic [DATA_W-1:0]  recData,
  input logic               recErr,
  input logic [NUM_BUS-1:0] overflow,
  input logic [NUM_BUS-1:0] pSel,
  input logic [NUM_BUS-1:0] pEnable,
  input logic [31:0]        timeNow,
  input logic [3:0]         popVec
);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recReady) |=> (recValid && $stable(recTime) && $stable(recBus)
      && $stable(recWrite) && $stable(recAddr) && $stable(recData) && $stable(recErr)));

  p_pop_handshake_r10: assert property (@(posedge clk) disable iff (!rstN)
    (popVec != 4'd0) |-> (recValid && recReady));

  p_single_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(popVec));

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(overflow) & ~overflow) == '0));

  p_overflow_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((overflow & ~$past(overflow) & ~$past(pSel & pEnable)) == '0));

  p_time_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (timeNow == $past(timeNow) + 32'd2));

  p_bus_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> (int'(recBus) < NUM_BUS));

endmodule

bind apb_txn_monitor apb_mon_checker #(
  .NUM_BUS(NUM_BUS),
  .DATA_W (DATA_W)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .recValid(recValid),
  .recReady(recReady),
  .recTime (recTime),
  .recBus  (recBus),
  .recWrite(recWrite),
  .recAddr (recAddr),
  .recData (recData),
  .recErr  (recErr),
  .overflow(overflow),
  .pSel    (pSel),
  .pEnable (pEnable),
  .timeNow (timeNow),
  .popVec  (popVec)
);

// File: tb/test_apb_txn_monitor.sv
module test_apb_txn_monitor;
  localparam int          CLK_PERIOD = 10;
  localparam int          NB         = 4;
  localparam int          DEPTH      = 4;
  localparam logic [3:0]  HASRDY     = 4'b0111;
  localparam logic [3:0]  HASERR     = 4'b1011;
  localparam logic [23:0] ABITS      = {6'd32, 6'd32, 6'd9, 6'd32};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NB-1:0] pSel = '0, pEnable = '0, pWrite = '0, pReady = '0, pSlvErr = '0;
  logic [NB*32-1:0] pAddr = '0, pWdata = '0, pRdata = '0;
  logic recReady = 1'b0;
  logic recValid, recWrite, recErr;
  logic [31:0] recTime, recAddr, recData;
  logic [1:0] recBus;
  logic [NB-1:0] overflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_txn_monitor #(
    .NUM_BUS(NB), .ADDR_W(32), .DATA_W(32), .FIFO_DEPTH(DEPTH),
    .ADDR_BITS_VEC(ABITS), .HAS_READY(HASRDY), .HAS_ERR(HASERR)
  ) i_apb_txn_monitor (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pReady(pReady), .pSlvErr(pSlvErr), .pAddr(pAddr), .pWdata(pWdata),
    .pRdata(pRdata), .recValid(recValid), .recReady(recReady), .recTime(recTime),
    .recBus(recBus), .recWrite(recWrite), .recAddr(recAddr), .recData(recData),
    .recErr(recErr), .overflow(overflow)
  );

  typedef struct {
    logic [31:0] t;
    int          b;
    logic        w;
    logic [31:0] a;
    logic [31:0] d;
    logic        e;
  } mRec_t;

  mRec_t       mq [NB][$];
  logic [NB-1:0] mOvf = '0;
  bit          mHeld = 0;
  int          mHeldIdx = 0;
  logic [31:0] mTime = '0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(input int b);
    int bits = int'(ABITS[b*6 +: 6]);
    if (bits >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << bits) - 32'd1;
  endfunction

  function automatic int grantOf();
    if (mHeld) return mHeldIdx;
    for (int b = 0; b < NB; b++) if (mq[b].size() > 0) return b;
    return 0;
  endfunction

  function automatic bit anyQueued();
    for (int b = 0; b < NB; b++) if (mq[b].size() > 0) return 1;
    return 0;
  endfunction

  // Compare the outputs, advance the model across the next edge, wait a cycle.
  task automatic tick();
    bit v = anyQueued();
    int g = grantOf();
    check("R1 R2 recValid", 64'(recValid), 64'(v));
    if (v) begin
      check("R7 recTime", 64'(recTime), 64'(mq[g][0].t));
      check("R6 R8 R10 recBus", 64'(recBus), 64'(g));
      check("R4 recWrite", 64'(recWrite), 64'(mq[g][0].w));
      check("R5 recAddr", 64'(recAddr), 64'(mq[g][0].a));
      check("R4 recData", 64'(recData), 64'(mq[g][0].d));
      check("R3 recErr", 64'(recErr), 64'(mq[g][0].e));
    end
    check("R9 overflow", 64'(overflow), 64'(mOvf));
    for (int b = 0; b < NB; b++) begin
      bit rdy = HASRDY[b] ? pReady[b] : 1'b1;
      if (pSel[b] && pEnable[b] && rdy) begin
        if (mq[b].size() >= DEPTH) mOvf[b] = 1'b1;
        else begin
          mRec_t r;
          r.t = mTime;
          r.b = b;
          r.w = pWrite[b];
          r.a = pAddr[b*32 +: 32] & maskOf(b);
          r.d = pWrite[b] ? pWdata[b*32 +: 32] : pRdata[b*32 +: 32];
          r.e = HASERR[b] ? pSlvErr[b] : 1'b0;
          mq[b].push_back(r);
        end
      end
    end
    if (v && recReady) void'(mq[g].pop_front());
    mHeld = v && !recReady;
    mHeldIdx = g;
    mTime = mTime + 32'd2;
    @(negedge clk);
  endtask

  task automatic idleBuses();
    pSel = '0; pEnable = '0; pWrite = '0; pReady = '0; pSlvErr = '0;
  endtask

  task automatic setXfer(input int b, input logic w, input logic [31:0] a,
                         input logic [31:0] d, input logic rdy, input logic err);
    pSel[b] = 1'b1; pEnable[b] = 1'b1; pWrite[b] = w; pReady[b] = rdy;
    pSlvErr[b] = err; pAddr[b*32 +: 32] = a;
    if (w) pWdata[b*32 +: 32] = d; else pRdata[b*32 +: 32] = d;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset recValid", 64'(recValid), 64'd0);
    check("R11 reset overflow", 64'(overflow), 64'd0);
    rstN = 1'b1;

    // R4 lone write on bus 0 with a wait state first.
    recReady = 1'b1;
    pSel[0] = 1'b1; pEnable[0] = 1'b0; pWrite[0] = 1'b1;
    tick();
    setXfer(0, 1'b1, 32'h0000_1234, 32'hCAFE_0001, 1'b0, 1'b0);
    tick();
    setXfer(0, 1'b1, 32'h0000_1234, 32'hCAFE_0001, 1'b1, 1'b0);
    tick();
    idleBuses();
    repeat (3) tick();

    // R5 read on the 9-bit bus 1 beyond its width.
    setXfer(1, 1'b0, 32'hFFFF_FFFF, 32'h1357_9BDF, 1'b1, 1'b0);
    tick();
    idleBuses();
    repeat (2) tick();

    // R2 bus 3 has no ready: low ready still completes. R3 error handling.
    setXfer(3, 1'b1, 32'h0000_0040, 32'h0000_0001, 1'b0, 1'b1);
    setXfer(2, 1'b0, 32'h0000_0080, 32'h0BAD_0BAD, 1'b1, 1'b1);
    setXfer(0, 1'b0, 32'h0000_00C0, 32'h0000_00EE, 1'b1, 1'b1);
    tick();
    idleBuses();
    repeat (5) tick();

    // R8 all four complete in one cycle: drained lowest index first.
    for (int b = 0; b < NB; b++) setXfer(b, b[0], 32'h100 + 32'(b), 32'hA0 + 32'(b), 1'b1, 1'b0);
    tick();
    idleBuses();
    repeat (6) tick();

    // R9 R10 stalled consumer, bus 0 completes six times in a row.
    recReady = 1'b0;
    for (int k = 0; k < 6; k++) begin
      idleBuses();
      setXfer(0, 1'b1, 32'h200 + 32'(k), 32'h5000 + 32'(k), 1'b1, 1'b0);
      if (k == 2) setXfer(1, 1'b0, 32'h0000_0300, 32'h7777_0000, 1'b1, 1'b0);
      tick();
    end
    idleBuses();
    repeat (3) tick();
    check("R9 flag set after drop", 64'(overflow[0]), 64'd1);
    recReady = 1'b1;
    repeat (8) tick();
    check("R9 flag sticky after drain", 64'(overflow[0]), 64'd1);

    // Random traffic with random back-pressure.
    for (int c = 0; c < 3000; c++) begin
      for (int b = 0; b < NB; b++) begin
        pSel[b]    = ($urandom_range(0, 3) != 0);
        pEnable[b] = ($urandom_range(0, 2) != 0);
        pReady[b]  = ($urandom_range(0, 2) != 0);
        pWrite[b]  = 1'($urandom);
        pSlvErr[b] = ($urandom_range(0, 7) == 0);
        pAddr[b*32 +: 32]  = $urandom;
        pWdata[b*32 +: 32] = $urandom;
        pRdata[b*32 +: 32] = $urandom;
      end
      recReady = (c % 500 < 100) ? ($urandom_range(0, 5) == 0) : 1'($urandom);
      tick();
    end
    idleBuses();
    recReady = 1'b1;
    repeat (20) tick();

    finished = 1;
    summary();
    $finish;
  end

endmodule